// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the 13-bit instruction address of a small microcontroller core and the hidden return-address stack that goes with it. Each clock cycle the core raises at most one control strobe, and the block works out the next address from it. The strobes are: advance by one, write the low address byte, jump, call, take an interrupt, or return. When two or more strobes are raised together, a fixed priority picks one of them. The address bits above the low byte never come straight from software. They come from a separate upper-address latch that the core supplies. A low-byte write takes five bits from that latch, while a jump or call takes only its top two bits, because the 11-bit immediate already covers the lower part of the address.

The return stack holds eight 13-bit addresses in a ring. A call or an interrupt stores the address of the next instruction. A return (the core maps its three return flavours onto one strobe) reloads the most recently stored address. The stack pointer cannot be seen from outside, and nothing detects overflow or underflow. A ninth store replaces the oldest entry, and a return with no valid entry left wraps the pointer and delivers whatever that slot holds. Instruction fetch and decode are left to the core.

The selected operation is an enumerated value, `op_e`. `OP_HOLD` applies when no strobe is raised. The others are `OP_INC`, `OP_PCL` (low-byte write), `OP_GOTO`, `OP_CALL`, `OP_RET` and `OP_IRQ`. Every operation acts at the next rising clock edge.

Top module: `pc_unit_top`

## Requirements
- R1: While reset is asserted, and right after it is released, pc_o is 0x0000 and all stack slots hold 0x0000.
- R2: With only the advance strobe raised, pc_o becomes the old pc_o plus one, and 0x1FFF wraps to 0x0000.
- R3: A low-byte write loads pc_o with {latch_i[4:0], pcl_data_i[7:0]}.
- R4: A jump loads pc_o with {latch_i[4:3], imm_i[10:0]} and leaves the stack untouched.
- R5: A call loads pc_o the same way as a jump and stores the old pc_o plus one on the stack.
- R6: A return loads pc_o with the most recently stored stack entry and removes it, so entries come back last-in, first-out.
- R7: An interrupt loads pc_o with 0x0004 and stores the old pc_o plus one on the stack.
- R8: The stack is an 8-slot ring. After nine stores, the first stored address is gone. Eight returns then give the 9th down to the 2nd stored address, and a further return gives the 9th again.
- R9: A return with the stack empty since reset wraps the pointer and loads 0x0000, with no error of any kind.
- R10: The strobes take effect in this priority order: interrupt, return, call, jump, low-byte write, advance. With no strobe raised, pc_o holds its value.
- R11: pc_o changes only at the rising clock edge that samples a strobe, and never combinationally on an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Advance address by one |
| pcl_wr_i | input | 1 | Write low address byte |
| goto_i | input | 1 | Jump to immediate target |
| call_i | input | 1 | Call immediate target, store return address |
| irq_i | input | 1 | Interrupt branch to vector, store return address |
| ret_i | input | 1 | Return to last stored address |
| pcl_data_i | input | 8 | Data for low-byte write |
| imm_i | input | 11 | Jump/call immediate target |
| latch_i | input | 5 | Upper-address latch value |
| pc_o | output | 13 | Current program counter |

## Verification
Every strobe shows its result on pc_o exactly one rising edge after it is sampled, and this includes a return, whose stack read is combinational ahead of the address register. The driver applies the strobes on the falling edge and queues the expected address. The monitor pops that address and compares it 2 ns after the next rising edge, so each comparison falls in the single cycle where the result is due. For one step the driver also samples pc_o just after applying the strobes, before the edge, to confirm that the value has not moved yet.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
    typedef enum logic [2:0] {
        OP_HOLD,
        OP_INC,
        OP_PCL,
        OP_GOTO,
        OP_CALL,
        OP_RET,
        OP_IRQ
    } op_e;
endpackage

// File: rtl/pcu_op_select.sv
module pcu_op_select
    import pcu_pkg::*;
(
    input  logic inc_i,
    input  logic pcl_wr_i,
    input  logic goto_i,
    input  logic call_i,
    input  logic irq_i,
    input  logic ret_i,
    output op_e  op_o
);
    // R10: fixed priority among the strobes
    always_comb begin
        if (irq_i)         op_o = OP_IRQ;
        else if (ret_i)    op_o = OP_RET;
        else if (call_i)   op_o = OP_CALL;
        else if (goto_i)   op_o = OP_GOTO;
        else if (pcl_wr_i) op_o = OP_PCL;
        else if (inc_i)    op_o = OP_INC;
        else               op_o = OP_HOLD;
    end
endmodule

// File: rtl/pcu_ret_stack.sv
module pcu_ret_stack #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] push_val_i,
    output logic [WIDTH-1:0] top_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W-1:0] PTR_ONE = 1;

    logic [PTR_W-1:0] ptr_q;
    logic [PTR_W-1:0] rd_idx;
    logic [WIDTH-1:0] slot_q [DEPTH];

    // R8/R9: pointer wraps freely in both directions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_q + PTR_ONE;
        else if (pop_i)  ptr_q <= ptr_q - PTR_ONE;
    end

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    slot_q[g] <= '0;
                else if (push_i && (ptr_q == PTR_W'(g)))
                    slot_q[g] <= push_val_i;
            end
        end
    endgenerate

    assign rd_idx = ptr_q - PTR_ONE;
    assign top_o  = slot_q[rd_idx];

    a_r10_one_stack_op: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_i, pop_i}));
    a_r8_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |=> ptr_q == $past(ptr_q) + PTR_ONE);
    a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |=> ptr_q == $past(ptr_q) - PTR_ONE);
    a_r8_idle_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> $stable(ptr_q));
endmodule

// File: rtl/pcu_next_addr.sv
module pcu_next_addr
    import pcu_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int IMM_W  = 11,
    parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
    input  op_e                    op_i,
    input  logic [PC_W-1:0]        pc_i,
    input  logic [DATA_W-1:0]      pcl_data_i,
    input  logic [IMM_W-1:0]       imm_i,
    input  logic [PC_W-DATA_W-1:0] latch_i,
    input  logic [PC_W-1:0]        stack_top_i,
    output logic [PC_W-1:0]        next_o,
    output logic [PC_W-1:0]        ret_addr_o
);
    localparam int LAT_W = PC_W - DATA_W;
    localparam int JHI_W = PC_W - IMM_W;
    localparam logic [PC_W-1:0] ONE = 1;

    logic [PC_W-1:0] jump_tgt;

    assign ret_addr_o = pc_i + ONE;
    assign jump_tgt   = {latch_i[LAT_W-1 -: JHI_W], imm_i};

    always_comb begin
        unique case (op_i)
            OP_IRQ:  next_o = VECTOR;
            OP_RET:  next_o = stack_top_i;
            OP_CALL: next_o = jump_tgt;
            OP_GOTO: next_o = jump_tgt;
            OP_PCL:  next_o = {latch_i, pcl_data_i};
            OP_INC:  next_o = ret_addr_o;
            OP_HOLD: next_o = pc_i;
            default: next_o = pc_i;
        endcase
    end
endmodule

// File: rtl/pc_unit_top.sv
module pc_unit_top
    import pcu_pkg::*;
#(
    parameter int PC_W   = 13,
    parameter int DATA_W = 8,
    parameter int IMM_W  = 11,
    parameter int DEPTH  = 8,
    parameter logic [PC_W-1:0] VECTOR = 13'h0004
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc_i,
    input  logic                    pcl_wr_i,
    input  logic                    goto_i,
    input  logic                    call_i,
    input  logic                    irq_i,
    input  logic                    ret_i,
    input  logic [DATA_W-1:0]       pcl_data_i,
    input  logic [IMM_W-1:0]        imm_i,
    input  logic [PC_W-DATA_W-1:0]  latch_i,
    output logic [PC_W-1:0]         pc_o
);
    localparam int JHI_W = PC_W - IMM_W;
    localparam int LAT_W = PC_W - DATA_W;
    localparam logic [PC_W-1:0] ONE = 1;

    op_e             op;
    logic [PC_W-1:0] pc_q;
    logic [PC_W-1:0] pc_d;
    logic [PC_W-1:0] ret_addr;
    logic [PC_W-1:0] stack_top;
    logic            push;
    logic            pop;

    pcu_op_select u_sel (
        .inc_i    (inc_i),
        .pcl_wr_i (pcl_wr_i),
        .goto_i   (goto_i),
        .call_i   (call_i),
        .irq_i    (irq_i),
        .ret_i    (ret_i),
        .op_o     (op)
    );

    always_comb begin
        unique case (op)
            OP_CALL, OP_IRQ: begin push = 1'b1; pop = 1'b0; end
            OP_RET:          begin push = 1'b0; pop = 1'b1; end
            default:         begin push = 1'b0; pop = 1'b0; end
        endcase
    end

    pcu_ret_stack #(.DEPTH(DEPTH), .WIDTH(PC_W)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .pop_i      (pop),
        .push_val_i (ret_addr),
        .top_o      (stack_top)
    );

    pcu_next_addr #(.PC_W(PC_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .VECTOR(VECTOR)) u_next (
        .op_i        (op),
        .pc_i        (pc_q),
        .pcl_data_i  (pcl_data_i),
        .imm_i       (imm_i),
        .latch_i     (latch_i),
        .stack_top_i (stack_top),
        .next_o      (pc_d),
        .ret_addr_o  (ret_addr)
    );

    // R1, R11: single address register, cleared by reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;

    a_r7_vector: assert property (@(posedge clk) disable iff (!rst_n)
        irq_i |=> pc_o == VECTOR);
    a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !pcl_wr_i && !goto_i && !call_i && !irq_i && !ret_i)
        |=> pc_o == $past(pc_o) + ONE);
    a_r4_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (goto_i && !call_i && !irq_i && !ret_i)
        |=> pc_o == {$past(latch_i[LAT_W-1 -: JHI_W]), $past(imm_i)});
    a_r3_low_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pcl_wr_i && !goto_i && !call_i && !irq_i && !ret_i)
        |=> pc_o == {$past(latch_i), $past(pcl_data_i)});
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !pcl_wr_i && !goto_i && !call_i && !irq_i && !ret_i)
        |=> $stable(pc_o));
endmodule

// File: tb/tb_pc_unit_top.sv
`timescale 1ns/1ps
module tb_pc_unit_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        inc_i = 0, pcl_wr_i = 0, goto_i = 0, call_i = 0, irq_i = 0, ret_i = 0;
    logic [7:0]  pcl_data_i = '0;
    logic [10:0] imm_i = '0;
    logic [4:0]  latch_i = '0;
    logic [12:0] pc_o;

    int compared = 0;
    int mismatched = 0;

    logic [12:0] exp_q [$];
    string       tag_q [$];

    logic [12:0] m_pc;
    logic [12:0] m_stk [8];
    logic [2:0]  m_ptr;

    always #5 clk = ~clk;

    pc_unit_top dut (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_i), .pcl_wr_i(pcl_wr_i),
        .goto_i(goto_i), .call_i(call_i), .irq_i(irq_i), .ret_i(ret_i),
        .pcl_data_i(pcl_data_i), .imm_i(imm_i), .latch_i(latch_i), .pc_o(pc_o)
    );

    task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: pc_o actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // monitor: one expected item per driven step, due 2 ns after the next rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            string t;
            logic [12:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, pc_o, e);
        end
    end

    task automatic m_push(input logic [12:0] v);
        m_stk[m_ptr] = v;
        m_ptr = m_ptr + 3'd1;
    endtask

    task automatic step(input bit i, input bit p, input bit g, input bit c,
                        input bit q, input bit r, input logic [7:0] d,
                        input logic [10:0] im, input logic [4:0] lat, input string tag);
        @(negedge clk);
        inc_i = i; pcl_wr_i = p; goto_i = g; call_i = c; irq_i = q; ret_i = r;
        pcl_data_i = d; imm_i = im; latch_i = lat;
        if (q) begin m_push(m_pc + 13'd1); m_pc = 13'h0004; end
        else if (r) begin m_ptr = m_ptr - 3'd1; m_pc = m_stk[m_ptr]; end
        else if (c) begin m_push(m_pc + 13'd1); m_pc = {lat[4:3], im}; end
        else if (g) m_pc = {lat[4:3], im};
        else if (p) m_pc = {lat, d};
        else if (i) m_pc = m_pc + 13'd1;
        exp_q.push_back(m_pc);
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        {inc_i, pcl_wr_i, goto_i, call_i, irq_i, ret_i} = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        {inc_i, pcl_wr_i, goto_i, call_i, irq_i, ret_i} = '0;
        rst_n = 1'b0;
        m_pc = '0; m_ptr = '0;
        for (int k = 0; k < 8; k++) m_stk[k] = '0;
        #3;
        check("R1 during reset", pc_o, 13'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 after release", pc_o, 13'h0000);
    endtask

    initial begin
        #2_000_000;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        do_reset();
        // R2 advance
        step(1,0,0,0,0,0, 8'h00, 11'h000, 5'h00, "R2 inc");
        step(1,0,0,0,0,0, 8'h00, 11'h000, 5'h00, "R2 inc");
        // R3 low-byte write
        step(0,1,0,0,0,0, 8'h34, 11'h000, 5'h1A, "R3 pcl write");
        // R11: value unchanged before the edge
        @(negedge clk);
        {inc_i, pcl_wr_i, goto_i, call_i, irq_i, ret_i} = '0;
        @(posedge clk); #2;
        @(negedge clk);
        goto_i = 1'b1; imm_i = 11'h123; latch_i = 5'h18;
        #1;
        check("R11 no early change", pc_o, m_pc);
        goto_i = 1'b0;
        // R4 jump
        step(0,0,1,0,0,0, 8'h00, 11'h123, 5'h18, "R4 goto");
        // R5 call, R7 interrupt, R6 returns
        step(0,0,0,1,0,0, 8'h00, 11'h055, 5'h00, "R5 call");
        step(0,0,0,0,1,0, 8'h00, 11'h000, 5'h00, "R7 irq");
        step(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R6 ret from irq");
        step(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R6 ret from call");
        // R10 priority
        step(1,1,1,1,1,1, 8'hAA, 11'h7FF, 5'h1F, "R10 irq wins");
        step(1,1,1,1,0,1, 8'hAA, 11'h7FF, 5'h1F, "R10 ret over call");
        step(1,1,1,1,0,0, 8'hAA, 11'h2AA, 5'h08, "R10 call over goto");
        step(1,1,1,0,0,0, 8'hAA, 11'h155, 5'h10, "R10 goto over pcl");
        step(1,1,0,0,0,0, 8'h5C, 11'h000, 5'h0B, "R10 pcl over inc");
        step(0,0,0,0,0,0, 8'h00, 11'h000, 5'h00, "R10 hold");
        // R2 wrap
        step(0,1,0,0,0,0, 8'hFF, 11'h000, 5'h1F, "R3 pcl to top");
        step(1,0,0,0,0,0, 8'h00, 11'h000, 5'h00, "R2 wrap to zero");
        // R8 circular: nine calls then ten returns
        for (int k = 0; k < 9; k++)
            step(0,0,0,1,0,0, 8'h00, 11'(16 * k + 3), 5'(k), "R8 call fill");
        for (int k = 0; k < 10; k++)
            step(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R8 ret ring");
        // R9 underflow from reset
        idle();
        do_reset();
        step(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R9 empty pop");
        step(0,0,0,0,0,1, 8'h00, 11'h000, 5'h00, "R9 second empty pop");
        idle();
        @(posedge clk); #4;
        while (exp_q.size() > 0) begin @(posedge clk); #4; end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule